// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block decides which of five interrupt sources a small processor core services next. The sources are a non-maskable trap line, three restart lines (high, mid and low) and a general external request line. The block holds the global interrupt-enable flag and one mask bit for each restart line. The core pulses a sample strobe on the next-to-last cycle of each instruction. On that clock edge the block picks the highest-priority eligible request and commits to it.

One cycle after an accepting strobe, the block raises a one-cycle `take_irq` pulse. A restart source also raises `vec_valid` together with its fixed restart address, and the core jumps there without any bus acknowledge. The external source instead raises `inta_req`, so the core holds its program counter and runs an acknowledge cycle in which a device supplies the instruction. The high restart line and the trap line capture rising edges into latches. The mid and low restart lines are level sensitive.

Top module: `restart_irq_ctrl`

## Requirements
- R1: After reset, all outputs are 0, the interrupt-enable flag is clear and all three restart mask bits are set (masked). With only maskable requests active, a strobe is therefore not accepted.
- R2: Among eligible requests, priority from highest to lowest is trap, high, mid, low, external.
- R3: The trap is accepted regardless of the masks and the enable flag. It needs a rising edge on `trap_in`, and `trap_in` must still be high at the strobe. Its edge latch clears when it is accepted.
- R4: Requests are evaluated only on clock edges where `sample_stb` is 1. Without a strobe, `take_irq`, `vec_valid` and `inta_req` stay 0.
- R5: For a restart source, `vec_valid`=1, `inta_req`=0 and `vec_addr` is 0x0024 for trap, 0x003C for high, 0x0034 for mid and 0x002C for low.
- R6: For the external source, `inta_req`=1, `vec_valid`=0 and `vec_addr`=0.
- R7: `ie_set` sets the enable flag and `ie_clr` clears it. If both are 1 on the same edge, clear wins. With the flag clear, no maskable source is accepted.
- R8: Accepting any maskable source clears the enable flag on the accepting edge, overriding `ie_set`. Accepting the trap leaves the flag unchanged.
- R9: On a `mask_wr` edge with `mask_set_en`=1, the masks load from `mask_bits`: bit 2 masks high, bit 1 masks mid, bit 0 masks low, and 1 means masked. With `mask_set_en`=0 the masks are unchanged.
- R10: A rising edge on `hi_in` sets a latch that stays set after `hi_in` falls. The latch is cleared by accepting the high source, or by a `mask_wr` with `mask_clr_hi`=1. Mid and low are accepted only if their line is high at the strobe.
- R11: The outputs are registered. They are valid for exactly the one cycle after the accepting strobe edge and are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable trap request |
| hi_in | input | 1 | High restart request, edge captured |
| mid_in | input | 1 | Mid restart request, level |
| lo_in | input | 1 | Low restart request, level |
| ext_in | input | 1 | External request needing an acknowledge cycle |
| sample_stb | input | 1 | Sampling point from the core |
| ie_set | input | 1 | Enable-interrupts command |
| ie_clr | input | 1 | Disable-interrupts command |
| mask_wr | input | 1 | Mask write command |
| mask_set_en | input | 1 | Mask bits are loaded only when 1 |
| mask_bits | input | 3 | New masks: [2] high, [1] mid, [0] low |
| mask_clr_hi | input | 1 | Clears the high edge latch on a mask write |
| take_irq | output | 1 | Interrupt accepted |
| vec_valid | output | 1 | Internal restart, address on vec_addr |
| vec_addr | output | 16 | Restart address |
| inta_req | output | 1 | Run an acknowledge cycle |

## Verification
The hardest cases to reach are those where edge-captured state and level state disagree at the strobe. One is a trap whose edge was latched but whose line has dropped. Another is a high request that pulsed and vanished long before the sample. The bench builds these by raising a line for exactly one cycle and holding or releasing it before strobing. It also sweeps all 32 combinations of simultaneous requests and all 8 mask patterns, computing the winner arithmetically. It then re-strobes right after an acceptance to see whether the enable flag was cleared.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int NUM_SRC = 5;
    localparam int VEC_W   = 16;
    localparam int MASK_W  = 3;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_HI   = 3'd2,
        SRC_MID  = 3'd3,
        SRC_LO   = 3'd4,
        SRC_EXT  = 3'd5
    } src_e;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_HI   = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_MID  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;

    typedef struct packed {
        logic             take;
        logic             vvalid;
        logic             inta;
        logic [VEC_W-1:0] addr;
    } grant_t;

    // Pending vector index 0 is the highest priority.
    function automatic src_e src_of_idx(int idx);
        case (idx)
            0:       return SRC_TRAP;
            1:       return SRC_HI;
            2:       return SRC_MID;
            3:       return SRC_LO;
            4:       return SRC_EXT;
            default: return SRC_NONE;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        case (s)
            SRC_TRAP: return VEC_TRAP;
            SRC_HI:   return VEC_HI;
            SRC_MID:  return VEC_MID;
            SRC_LO:   return VEC_LO;
            default:  return '0;
        endcase
    endfunction

    function automatic logic is_restart(src_e s);
        return (s == SRC_TRAP) || (s == SRC_HI) || (s == SRC_MID) || (s == SRC_LO);
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter bit NEED_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic held_q;
    logic rise;

    assign rise = req & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            held_q <= 1'b0;
        end else begin
            prev_q <= req;
            held_q <= (held_q & ~clr) | rise;
        end
    end

    generate
        if (NEED_LEVEL) begin : g_gated
            assign pend = held_q & req;
        end else begin : g_plain
            assign pend = held_q;
        end
    endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_ctrl_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pend,
    output src_e         pick
);
    always_comb begin
        pick = SRC_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) pick = src_of_idx(i);
        end
    end
endmodule

// File: rtl/restart_irq_ctrl.sv
module restart_irq_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_in,
    input  logic             hi_in,
    input  logic             mid_in,
    input  logic             lo_in,
    input  logic             ext_in,
    input  logic             sample_stb,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             mask_wr,
    input  logic             mask_set_en,
    input  logic [MASK_W-1:0] mask_bits,
    input  logic             mask_clr_hi,
    output logic             take_irq,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_addr,
    output logic             inta_req
);
    localparam int NUM_EDGE = 2;

    logic              ie_q;
    logic [MASK_W-1:0] mask_q;
    logic [NUM_EDGE-1:0] edge_req, edge_clr, edge_pend;
    logic [NUM_SRC-1:0] pend;
    src_e              pick;
    logic              accept;
    grant_t            out_q;

    assign edge_req[0] = trap_in;
    assign edge_req[1] = hi_in;
    assign edge_clr[0] = accept && (pick == SRC_TRAP);
    assign edge_clr[1] = (accept && (pick == SRC_HI)) || (mask_wr && mask_clr_hi);

    generate
        for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
            irq_edge_latch #(.NEED_LEVEL(g == 0)) u_latch (
                .clk  (clk),
                .rst  (rst),
                .req  (edge_req[g]),
                .clr  (edge_clr[g]),
                .pend (edge_pend[g])
            );
        end
    endgenerate

    assign pend[0] = edge_pend[0];
    assign pend[1] = edge_pend[1] & ~mask_q[2] & ie_q;
    assign pend[2] = mid_in       & ~mask_q[1] & ie_q;
    assign pend[3] = lo_in        & ~mask_q[0] & ie_q;
    assign pend[4] = ext_in       & ie_q;

    irq_prio_pick #(.N(NUM_SRC)) u_pick (
        .pend (pend),
        .pick (pick)
    );

    assign accept = sample_stb && (pick != SRC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
            out_q  <= '0;
        end else begin
            if (accept && (pick != SRC_TRAP)) ie_q <= 1'b0;
            else if (ie_clr)                  ie_q <= 1'b0;
            else if (ie_set)                  ie_q <= 1'b1;

            if (mask_wr && mask_set_en) mask_q <= mask_bits;

            out_q <= '0;
            if (accept) begin
                out_q.take   <= 1'b1;
                out_q.vvalid <= is_restart(pick);
                out_q.inta   <= (pick == SRC_EXT);
                out_q.addr   <= vec_of(pick);
            end
        end
    end

    assign take_irq  = out_q.take;
    assign vec_valid = out_q.vvalid;
    assign inta_req  = out_q.inta;
    assign vec_addr  = out_q.addr;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sample_stb,
    input logic             trap_in,
    input logic             take_irq,
    input logic             vec_valid,
    input logic             inta_req,
    input logic [VEC_W-1:0] vec_addr,
    input logic             ie_q
);
    // R4
    take_only_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> $past(sample_stb));

    // R6
    kind_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(vec_valid && inta_req) && (take_irq == (vec_valid || inta_req)));

    // R5
    vector_legal_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_addr == VEC_TRAP || vec_addr == VEC_HI ||
                       vec_addr == VEC_MID  || vec_addr == VEC_LO));

    // R8
    ie_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        inta_req |-> !ie_q);

    // R3
    trap_level_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_addr == VEC_TRAP) |-> $past(trap_in));
endmodule

bind restart_irq_ctrl irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .trap_in    (trap_in),
    .take_irq   (take_irq),
    .vec_valid  (vec_valid),
    .inta_req   (inta_req),
    .vec_addr   (vec_addr),
    .ie_q       (ie_q)
);

// File: tb/restart_irq_ctrl_tb.sv
module restart_irq_ctrl_tb;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trap_in = 0, hi_in = 0, mid_in = 0, lo_in = 0, ext_in = 0;
    logic sample_stb = 0, ie_set = 0, ie_clr = 0;
    logic mask_wr = 0, mask_set_en = 0, mask_clr_hi = 0;
    logic [2:0] mask_bits = 3'b000;
    logic take_irq, vec_valid, inta_req;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    restart_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .trap_in(trap_in), .hi_in(hi_in), .mid_in(mid_in),
        .lo_in(lo_in), .ext_in(ext_in), .sample_stb(sample_stb), .ie_set(ie_set),
        .ie_clr(ie_clr), .mask_wr(mask_wr), .mask_set_en(mask_set_en),
        .mask_bits(mask_bits), .mask_clr_hi(mask_clr_hi), .take_irq(take_irq),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .inta_req(inta_req)
    );

    // expected packed {take, vvalid, inta, addr}
    task automatic check(string req, logic [18:0] act, logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] exp_of(int src); // 0 none,1 trap,2 hi,3 mid,4 lo,5 ext
        case (src)
            1: return {3'b110, 16'h0024};
            2: return {3'b110, 16'h003C};
            3: return {3'b110, 16'h0034};
            4: return {3'b110, 16'h002C};
            5: return {3'b101, 16'h0000};
            default: return 19'h0;
        endcase
    endfunction

    function automatic logic [18:0] outs();
        return {take_irq, vec_valid, inta_req, vec_addr};
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic strobe_check(string req, int src);
        sample_stb = 1;
        cyc();
        sample_stb = 0;
        check(req, outs(), exp_of(src));
    endtask

    task automatic mwrite(logic en, logic [2:0] bits, logic clr);
        mask_wr = 1; mask_set_en = en; mask_bits = bits; mask_clr_hi = clr;
        cyc();
        mask_wr = 0; mask_set_en = 0; mask_clr_hi = 0;
    endtask

    task automatic enable_ie();
        ie_set = 1; cyc(); ie_set = 0;
    endtask

    task automatic settle();
        trap_in = 0; hi_in = 0; mid_in = 0; lo_in = 0; ext_in = 0;
        mwrite(1'b0, 3'b000, 1'b1);
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        // R1: reset state of outputs
        check("R1", outs(), 19'h0);
        // R1: enable clear after reset, external ignored
        ext_in = 1; cyc();
        strobe_check("R1", 0);
        ext_in = 0;
        // R1: masks set after reset, mid ignored even with enable
        enable_ie(); mid_in = 1; cyc();
        strobe_check("R1", 0);
        mid_in = 0;

        // R4: no strobe, no output while requests are live
        ext_in = 1;
        for (int i = 0; i < 4; i++) begin
            cyc();
            check("R4", outs(), 19'h0);
        end
        settle();

        // R2/R5/R6: sweep of all request combinations
        for (int p = 0; p < 32; p++) begin
            int win;
            settle();
            mwrite(1'b1, 3'b000, 1'b0);
            enable_ie();
            trap_in = p[4]; hi_in = p[3]; mid_in = p[2]; lo_in = p[1]; ext_in = p[0];
            cyc();
            win = 0;
            for (int b = 4; b >= 0; b--) if (win == 0 && p[b]) win = 5 - b;
            strobe_check("R2", win);
        end

        // R9: mask sweep with high, mid and low all pending
        for (int m = 0; m < 8; m++) begin
            int win;
            settle();
            mwrite(1'b1, m[2:0], 1'b0);
            enable_ie();
            hi_in = 1; mid_in = 1; lo_in = 1;
            cyc();
            win = 0;
            for (int b = 2; b >= 0; b--) if (win == 0 && !m[b]) win = 4 - b;
            strobe_check("R9", win);
        end

        // R9: write without set enable leaves all masked
        settle();
        mwrite(1'b1, 3'b111, 1'b0);
        mwrite(1'b0, 3'b000, 1'b0);
        enable_ie(); mid_in = 1; cyc();
        strobe_check("R9", 0);

        // R3: trap with masks set and enable clear
        settle();
        ie_clr = 1; cyc(); ie_clr = 0;
        trap_in = 1; cyc();
        strobe_check("R3", 1);
        // R3: latch cleared on accept, line still high
        cyc();
        strobe_check("R3", 0);
        // R3: edge latched but level dropped before strobe
        settle();
        trap_in = 1; cyc(); trap_in = 0; cyc();
        strobe_check("R3", 0);

        // R10: high pulse persists after the line falls
        settle();
        mwrite(1'b1, 3'b000, 1'b0);
        enable_ie();
        hi_in = 1; cyc(); hi_in = 0;
        repeat (3) cyc();
        strobe_check("R10", 2);
        // R10: mask write clear removes the latched pulse
        enable_ie();
        hi_in = 1; cyc(); hi_in = 0; cyc();
        mwrite(1'b0, 3'b000, 1'b1);
        strobe_check("R10", 0);
        // R10: mid is level only
        mid_in = 1; cyc(); mid_in = 0; cyc();
        strobe_check("R10", 0);

        // R8: external accept clears enable, second strobe refused
        settle();
        enable_ie();
        ext_in = 1; cyc();
        strobe_check("R8", 5);
        strobe_check("R8", 0);
        // R8: trap accept keeps enable
        settle();
        enable_ie();
        trap_in = 1; cyc();
        strobe_check("R8", 1);
        trap_in = 0; ext_in = 1; cyc();
        strobe_check("R8", 5);
        // R8: accept overrides a simultaneous set
        settle();
        enable_ie();
        ext_in = 1; cyc();
        ie_set = 1;
        strobe_check("R8", 5);
        ie_set = 0;
        strobe_check("R8", 0);

        // R7: clear wins over set
        settle();
        ie_set = 1; ie_clr = 1; cyc(); ie_set = 0; ie_clr = 0;
        ext_in = 1; cyc();
        strobe_check("R7", 0);
        // R7: set alone enables
        enable_ie();
        strobe_check("R7", 5);

        // R11: one-cycle pulse after accepting edge
        settle();
        enable_ie();
        lo_in = 1;
        mwrite(1'b1, 3'b000, 1'b0);
        strobe_check("R11", 4);
        cyc();
        check("R11", outs(), 19'h0);
        settle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule